// File: doc/BRIEF.md
# Address-Range Attribute Register Bank

This block holds a bank of register pairs. Each pair describes one inclusive window of physical memory with a granularity of 64 KiB, and it tags that window with access flags. The even register of a pair holds the top of the window and the odd register holds the bottom. Software reaches the bank through two registers. An index register names one register of the bank. A data register then reads or writes the register that the index names. Writes land on the clock edge. Reads are combinational from the stored index.

A combinational lookup port takes a physical address. It reports a hit when at least one fully valid pair covers that address. It also reports the OR of the speculative flags of every covering pair, taken from each pair's bottom register. Because a bound is held as the physical address shifted right by four, physical address bit 16 lands at register bit 12. The low twelve register bits are left for flags.

Top module: `attr_range_bank`

## Requirements
- R1: After reset every register of the bank reads zero, and the lookup port reports no hit and zero attributes for any address.
- R2: Writing value i (i < 2*NUM_PAIRS) to the index register makes the data read port show register i combinationally from the next cycle on.
- R3: A data write changes the selected register on the next clock edge. When the index and the data are written in the same cycle, the data goes to the register that the index named before that edge.
- R4: Register layout: bits [REG_W-1:12] hold physical address bits [PA_W-1:16], bit 0 is the valid flag, bit 1 is the speculative flag, and bits [11:2] are not stored and read as zero.
- R5: An index value at or above 2*NUM_PAIRS makes a data write have no effect on any register, and the data read port returns zero while that index is selected.
- R6: Pair k consists of register 2k (upper bound) and register 2k+1 (lower bound). It covers address a when lower[PA_W-1:16] <= a[PA_W-1:16] <= upper[PA_W-1:16], which includes both end bytes of the window.
- R7: A pair takes part in a lookup only when the valid flag is set in both of its registers.
- R8: The attribute reported for a matching pair is the speculative flag of its lower-bound register. The speculative flag of the upper-bound register has no effect on lookups.
- R9: When several valid pairs cover an address, the lookup gives a single hit and the OR of their attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Index register write enable |
| idx_wdata | input | IDX_W | New index value |
| data_we | input | 1 | Write the register named by the index |
| data_wdata | input | REG_W | Data for the selected register |
| data_rdata | output | REG_W | Contents of the selected register, zero for an out-of-range index |
| lk_addr | input | PA_W | Physical address to look up |
| lk_hit | output | 1 | At least one valid pair covers lk_addr |
| lk_spec | output | 1 | OR of the lower-bound speculative flags of all covering pairs |

## Verification
The bench uses the defaults of four pairs and a 36-bit physical address. This gives a 32-bit register with a full 20-bit bound field and a 4-bit index. The index can therefore reach values from 8 to 15, which lie past the bank. That width brings the ignored-write and zero-read behaviour of out-of-range indices within reach. The full field width also lets the bench place a window at the very top of the address space, and four pairs give room for windows that overlap and for one half-valid pair.

// File: rtl/attr_range_pkg.sv
package attr_range_pkg;
   localparam int FLAG_VALID = 0;
   localparam int FLAG_SPEC  = 1;
   localparam int FLAG_BITS  = 12;
   localparam int REG_SHIFT  = 4;
   localparam int GRAN_LOG2  = 16;

   function automatic logic [63:0] keep_mask(input int reg_w);
      logic [63:0] m;
      m = '0;
      for (int b = 0; b < reg_w; b++) begin
         if (b >= FLAG_BITS || b == FLAG_VALID || b == FLAG_SPEC) m[b] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/attr_range_regs.sv
module attr_range_regs #(
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 4,
   parameter int REG_W    = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      idx_we,
   input  logic [IDX_W-1:0]          idx_wdata,
   input  logic                      data_we,
   input  logic [REG_W-1:0]          data_wdata,
   output logic [REG_W-1:0]          data_rdata,
   output logic [NUM_REGS*REG_W-1:0] regs_flat
);
   import attr_range_pkg::*;

   localparam logic [63:0]      KEEP64 = keep_mask(REG_W);
   localparam logic [REG_W-1:0] KEEP   = KEEP64[REG_W-1:0];

   logic [IDX_W-1:0] sel_q;
   logic             sel_ok;

   assign sel_ok = (32'(sel_q) < NUM_REGS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (idx_we) sel_q <= idx_wdata;
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [REG_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= '0;
         else if (data_we && sel_ok && (32'(sel_q) == r))
            val_q <= data_wdata & KEEP;
      end
      assign regs_flat[r*REG_W +: REG_W] = val_q;
   end

   always_comb begin
      data_rdata = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (sel_ok && (32'(sel_q) == r)) data_rdata = regs_flat[r*REG_W +: REG_W];
      end
   end
endmodule

// File: rtl/attr_range_match.sv
module attr_range_match #(
   parameter int REG_W = 32,
   parameter int AF_W  = 20
) (
   input  logic [REG_W-1:0] upper_reg,
   input  logic [REG_W-1:0] lower_reg,
   input  logic [AF_W-1:0]  addr_hi,
   output logic             hit,
   output logic             spec
);
   import attr_range_pkg::*;

   logic [AF_W-1:0] lo_f, hi_f;
   logic            both_valid;

   assign lo_f       = lower_reg[FLAG_BITS +: AF_W];
   assign hi_f       = upper_reg[FLAG_BITS +: AF_W];
   assign both_valid = upper_reg[FLAG_VALID] & lower_reg[FLAG_VALID];
   assign hit        = both_valid && (addr_hi >= lo_f) && (addr_hi <= hi_f);
   assign spec       = hit & lower_reg[FLAG_SPEC];
endmodule

// File: rtl/attr_range_bank.sv
module attr_range_bank #(
   parameter int NUM_PAIRS = 4,
   parameter int PA_W      = 36,
   parameter int IDX_W     = 4,
   parameter int REG_W     = PA_W - attr_range_pkg::REG_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_we,
   input  logic [IDX_W-1:0] idx_wdata,
   input  logic             data_we,
   input  logic [REG_W-1:0] data_wdata,
   output logic [REG_W-1:0] data_rdata,
   input  logic [PA_W-1:0]  lk_addr,
   output logic             lk_hit,
   output logic             lk_spec
);
   import attr_range_pkg::*;

   localparam int NUM_REGS = 2 * NUM_PAIRS;
   localparam int AF_W     = PA_W - GRAN_LOG2;

   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("NUM_PAIRS must be at least 1");
   end
   if (PA_W <= GRAN_LOG2 || PA_W > 64) begin : g_bad_pa
      $error("PA_W must lie in 17..64");
   end
   if (REG_W != PA_W - REG_SHIFT) begin : g_bad_reg
      $error("REG_W must equal PA_W - 4");
   end
   if ((1 << IDX_W) < NUM_REGS) begin : g_bad_idx
      $error("IDX_W too narrow for the bank");
   end

   logic [NUM_REGS*REG_W-1:0] regs_flat;
   logic [NUM_PAIRS-1:0]      pair_hit, pair_spec;

   attr_range_regs #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W),
      .REG_W    (REG_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_we     (idx_we),
      .idx_wdata  (idx_wdata),
      .data_we    (data_we),
      .data_wdata (data_wdata),
      .data_rdata (data_rdata),
      .regs_flat  (regs_flat)
   );

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      attr_range_match #(
         .REG_W (REG_W),
         .AF_W  (AF_W)
      ) u_match (
         .upper_reg (regs_flat[(2*k)*REG_W +: REG_W]),
         .lower_reg (regs_flat[(2*k+1)*REG_W +: REG_W]),
         .addr_hi   (lk_addr[PA_W-1:GRAN_LOG2]),
         .hit       (pair_hit[k]),
         .spec      (pair_spec[k])
      );
   end

   assign lk_hit  = |pair_hit;
   assign lk_spec = |pair_spec;
endmodule

// File: rtl/attr_range_bank_chk.sv
module attr_range_bank_chk #(
   parameter int NUM_PAIRS = 4,
   parameter int PA_W      = 36,
   parameter int IDX_W     = 4,
   parameter int REG_W     = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             idx_we,
   input logic [IDX_W-1:0] idx_wdata,
   input logic             data_we,
   input logic [REG_W-1:0] data_wdata,
   input logic [REG_W-1:0] data_rdata,
   input logic             lk_hit,
   input logic             lk_spec
);
   localparam logic [REG_W-1:0] KEEP = ({REG_W{1'b1}} << 12) | REG_W'(3);

   logic [IDX_W-1:0] shadow_idx;
   logic             in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_idx <= '0;
      else if (idx_we) shadow_idx <= idx_wdata;
   end
   assign in_range = 32'(shadow_idx) < 2 * NUM_PAIRS;

   AST_BAD_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_range |-> data_rdata == '0);  // R5
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !idx_we && in_range) |=> data_rdata == ($past(data_wdata) & KEEP));  // R3
   AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_we && !idx_we) |=> $stable(data_rdata));  // R2
   AST_SPEC_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_spec |-> lk_hit);  // R8
endmodule

bind attr_range_bank attr_range_bank_chk #(
   .NUM_PAIRS (NUM_PAIRS),
   .PA_W      (PA_W),
   .IDX_W     (IDX_W),
   .REG_W     (REG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .idx_we     (idx_we),
   .idx_wdata  (idx_wdata),
   .data_we    (data_we),
   .data_wdata (data_wdata),
   .data_rdata (data_rdata),
   .lk_hit     (lk_hit),
   .lk_spec    (lk_spec)
);

// File: tb/sim_attr_range_bank.sv
module sim_attr_range_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NP   = 4;
   localparam int PA_W = 36;
   localparam int IW   = 4;
   localparam int RW   = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          idx_we = 1'b0;
   logic [IW-1:0] idx_wdata = '0;
   logic          data_we = 1'b0;
   logic [RW-1:0] data_wdata = '0;
   logic [RW-1:0] data_rdata;
   logic [PA_W-1:0] lk_addr = '0;
   logic          lk_hit, lk_spec;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   attr_range_bank #(.NUM_PAIRS(NP), .PA_W(PA_W), .IDX_W(IW), .REG_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
      .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_spec(lk_spec));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_idx(input int i);
      @(negedge clk); idx_we = 1'b1; idx_wdata = IW'(i);
      @(negedge clk); idx_we = 1'b0;
   endtask

   task automatic wr(input int i, input logic [RW-1:0] v);
      set_idx(i);
      data_we = 1'b1; data_wdata = v;
      @(negedge clk); data_we = 1'b0;
   endtask

   task automatic rd(input int i, input logic [RW-1:0] exp, input string req);
      set_idx(i);
      #1 check(req, 64'(data_rdata), 64'(exp));
   endtask

   task automatic look(input logic [PA_W-1:0] a, input logic h, input logic s, input string req);
      @(negedge clk); lk_addr = a;
      #1;
      check({req, " hit"}, 64'(lk_hit), 64'(h));
      check({req, " spec"}, 64'(lk_spec), 64'(s));
   endtask

   // upper/lower bound register images (field = address >> 4, flags in low bits)
   function automatic logic [RW-1:0] ub(input logic [PA_W-1:0] a, input logic [1:0] f);
      return RW'(a >> 4) & 32'hFFFF_F000 | RW'(f);
   endfunction

   task automatic t_reset();
      for (int i = 0; i < 2*NP; i++) rd(i, '0, "R1 reset reg");
      look(36'h0_0000_0000, 1'b0, 1'b0, "R1 reset lookup");
      look(36'hF_FFFF_FFFF, 1'b0, 1'b0, "R1 reset lookup top");
   endtask

   task automatic t_layout();
      wr(3, 32'hFFFF_FFFF);
      rd(3, 32'hFFFF_F003, "R4 masked flag bits");
      rd(2, 32'h0, "R2 neighbour untouched");
      wr(3, 32'h0);
      rd(3, 32'h0, "R2 cleared");
   endtask

   task automatic t_timing();
      set_idx(6);
      @(negedge clk); data_we = 1'b1; data_wdata = 32'h0ABC_D001;
      #1 check("R3 before edge", 64'(data_rdata), 64'h0);
      @(negedge clk); data_we = 1'b0;
      check("R3 after edge", 64'(data_rdata), 64'h0ABC_D001);
      // same-cycle index and data write: data goes to old index (6)
      @(negedge clk); idx_we = 1'b1; idx_wdata = 4'd7; data_we = 1'b1; data_wdata = 32'h1234_5003;
      @(negedge clk); idx_we = 1'b0; data_we = 1'b0;
      #1 check("R3 new index untouched", 64'(data_rdata), 64'h0);
      rd(6, 32'h1234_5003, "R3 old index written");
      wr(6, 32'h0);
   endtask

   task automatic t_bad_idx();
      wr(9, 32'hFFFF_F003);
      #1 check("R5 read at idx 9", 64'(data_rdata), 64'h0);
      wr(15, 32'hAAAA_A001);
      #1 check("R5 read at idx 15", 64'(data_rdata), 64'h0);
      for (int i = 0; i < 2*NP; i++) rd(i, '0, "R5 bank unchanged");
   endtask

   task automatic t_range();
      wr(0, ub(36'h0_0003_FFFF, 2'b01));
      wr(1, ub(36'h0_0001_0000, 2'b11));
      rd(0, 32'h0000_3001, "R6 upper image");
      look(36'h0_0000_FFFF, 1'b0, 1'b0, "R6 below lower");
      look(36'h0_0001_0000, 1'b1, 1'b1, "R6 lower edge");
      look(36'h0_0002_1234, 1'b1, 1'b1, "R6 inside");
      look(36'h0_0003_FFFF, 1'b1, 1'b1, "R6 upper edge");
      look(36'h0_0004_0000, 1'b0, 1'b0, "R6 above upper");
   endtask

   task automatic t_valid();
      wr(2, ub(36'h0_0005_FFFF, 2'b00));
      wr(3, ub(36'h0_0005_0000, 2'b01));
      look(36'h0_0005_0000, 1'b0, 1'b0, "R7 upper invalid");
      wr(2, ub(36'h0_0005_FFFF, 2'b11));
      look(36'h0_0005_8000, 1'b1, 1'b0, "R8 upper spec ignored");
      wr(3, ub(36'h0_0005_0000, 2'b00));
      look(36'h0_0005_8000, 1'b0, 1'b0, "R7 lower invalid");
      wr(3, ub(36'h0_0005_0000, 2'b01));
   endtask

   task automatic t_overlap();
      wr(4, ub(36'h0_0005_FFFF, 2'b01));
      wr(5, ub(36'h0_0003_0000, 2'b11));
      look(36'h0_0005_0000, 1'b1, 1'b1, "R9 two pairs OR");
      look(36'h0_0004_0000, 1'b1, 1'b1, "R9 single pair");
      look(36'h0_0003_0000, 1'b1, 1'b1, "R9 pair0 and pair2");
      wr(6, ub(36'hF_FFFF_FFFF, 2'b01));
      wr(7, ub(36'hF_FFFF_0000, 2'b01));
      look(36'hF_FFFF_FFFF, 1'b1, 1'b0, "R6 top of space");
      look(36'hF_FFFE_FFFF, 1'b0, 1'b0, "R6 just below top window");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_timing();
      t_bad_idx();
      t_range();
      t_valid();
      t_overlap();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule